// File: doc/BRIEF.md
# 8-bit Timer/Counter with Power-of-Two Prescaler

This block is an 8-bit up-counter that software can load at any time and that reports each wrap from FFh to 00h with a one-clock pulse to an interrupt controller. It has two count sources. One is an internal instruction-cycle strobe that fires once every four system clocks. The other is an external pin, which is synchronised and then edge-detected on the rising or the falling edge, as configured.

An optional prescaler can sit between the chosen source and the counter. It divides the event rate by 2^(n+1), where n is a 3-bit rate code, so the ratio runs from 2 to 256. When the prescaler is not given to the timer, every source event advances the counter directly. A software load clears the prescaler. It also holds the counter still for the next two instruction cycles, so that a value just written is not stepped at once.

Top module: `evt_timer8`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `count_q` reads 00h and `ovf_pulse` reads 0.
- R2: A write (`wr_en`=1 at a clock edge) makes `count_q` equal `wr_data` after that edge. A write takes priority over any increment on the same edge.
- R3: With `cfg_src_pin`=0 and `cfg_psc_on`=0, the counter advances by one on every instruction-cycle boundary. Boundaries are the clock edges numbered 3, 7, 11 and so on, counting the first edge with `rst` low as edge 0.
- R4: With `cfg_src_pin`=1 and `cfg_edge_fall`=0, every 0-to-1 change of `cnt_pin` advances the counter. The pin passes through two synchronising flops, so a change sampled at edge A shows in `count_q` after edge A+2. Instruction-cycle boundaries have no effect in this mode.
- R5: With `cfg_src_pin`=1 and `cfg_edge_fall`=1, only 1-to-0 changes of `cnt_pin` advance the counter, with the same latency as R4. Rising changes are ignored.
- R6: With `cfg_psc_on`=1 and rate code n on `cfg_rate`, the counter advances once per 2^(n+1) source events (n=0 gives 2, n=7 gives 256).
- R7: A write clears the prescaler. Source events at the instruction-cycle boundaries of the next two instruction cycles after the write are discarded.
- R8: When the counter steps from FFh to 00h, `ovf_pulse` is high for exactly one clock, in the same cycle that `count_q` first reads 00h.
- R9: Between writes, `count_q` changes only by stepping up by one, modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_pin | input | 1 | External count input (asynchronous) |
| cfg_src_pin | input | 1 | Count source: 0 selects the instruction-cycle strobe, 1 selects the pin |
| cfg_edge_fall | input | 1 | Pin edge: 0 selects rising, 1 selects falling |
| cfg_psc_on | input | 1 | 1 assigns the prescaler to the timer |
| cfg_rate | input | 3 | Prescale code n, giving a ratio of 2^(n+1) |
| wr_en | input | 1 | Software write strobe for the counter |
| wr_data | input | 8 | Value to load |
| count_q | output | 8 | Current counter value |
| ovf_pulse | output | 1 | One-clock pulse on the wrap from FFh to 00h |

## Verification
The assertions check on every cycle that an overflow pulse never lasts two clocks and always coincides with a zero count. They also check that a load appears on the next edge, that the cycle after a load holds the loaded value, and that between loads the count only steps up by one.

Only the directed scenarios can show the exact timing. That covers the first step landing on the third instruction boundary after a load, the prescaler ratios 2, 8 and 256 measured after a load clears the prescaler, the three-clock latency of the pin path, and the rejection of the unselected pin edge.

// File: rtl/evt_timer8_pkg.sv
package evt_timer8_pkg;
  typedef enum logic {SRC_CYCLE = 1'b0, SRC_PIN = 1'b1} cnt_src_e;

  typedef struct packed {
    cnt_src_e   src;
    logic       edge_fall;
    logic       psc_on;
    logic [2:0] rate;
  } tmr_cfg_t;
endpackage

// File: rtl/evtt_phase.sv
module evtt_phase #(
  parameter int CLK_PER_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  output logic cyc_tick
);
  localparam int CYC_W = (CLK_PER_CYC > 1) ? $clog2(CLK_PER_CYC) : 1;
  localparam logic [CYC_W-1:0] PH_LAST = CYC_W'(CLK_PER_CYC - 1);

  logic [CYC_W-1:0] ph;

  always_ff @(posedge clk) begin
    if (rst)                ph <= '0;
    else if (ph == PH_LAST) ph <= '0;
    else                    ph <= ph + CYC_W'(1);
  end

  // strobe on the last clock of each instruction cycle
  assign cyc_tick = (ph == PH_LAST);
endmodule

// File: rtl/evtt_edge.sv
module evtt_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic fall_sel,
  output logic pin_evt
);
  // SYNC_STAGES synchroniser flops plus one history flop
  logic [SYNC_STAGES:0] sh;
  logic synced, prev;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SYNC_STAGES-1:0], pin};
  end

  assign synced  = sh[SYNC_STAGES-1];
  assign prev    = sh[SYNC_STAGES];
  assign pin_evt = fall_sel ? (prev & ~synced) : (synced & ~prev);
endmodule

// File: rtl/evtt_prescale.sv
module evtt_prescale #(
  parameter int PSC_W  = 8,
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              on,
  input  logic [RATE_W-1:0] rate,
  input  logic              evt,
  output logic              inc
);
  logic [PSC_W-1:0] psc;
  logic [PSC_W-1:0] mask;

  // rate n selects the low n+1 bits; the divider wraps there
  always_comb begin
    mask = '0;
    for (int i = 0; i < PSC_W; i++) begin
      if (i <= int'(rate)) mask[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr)     psc <= '0;
    else if (evt && on) psc <= psc + PSC_W'(1);
  end

  assign inc = on ? (evt && ((psc & mask) == mask)) : evt;
endmodule

// File: rtl/evtt_core.sv
module evtt_core #(
  parameter int CNT_W   = 8,
  parameter int INH_CYC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             cyc_tick,
  input  logic             inc,
  output logic             gate_open,
  output logic [CNT_W-1:0] count_q,
  output logic             ovf_q
);
  localparam int INH_W = $clog2(INH_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [INH_W-1:0] inh;

  always_ff @(posedge clk) begin
    if (rst)                         inh <= '0;
    else if (wr_en)                  inh <= INH_W'(INH_CYC);
    else if (cyc_tick && inh != '0)  inh <= inh - INH_W'(1);
  end

  assign gate_open = (inh == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else if (wr_en) begin
      count_q <= wr_data;
      ovf_q   <= 1'b0;
    end else if (inc) begin
      count_q <= count_q + CNT_W'(1);
      ovf_q   <= (count_q == CNT_MAX);
    end else begin
      ovf_q   <= 1'b0;
    end
  end
endmodule

// File: rtl/evt_timer8.sv
module evt_timer8
  import evt_timer8_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PSC_W       = 8,
  parameter int RATE_W      = 3,
  parameter int CLK_PER_CYC = 4,
  parameter int SYNC_STAGES = 2,
  parameter int INH_CYC     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_pin,
  input  logic              cfg_src_pin,
  input  logic              cfg_edge_fall,
  input  logic              cfg_psc_on,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic              wr_en,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  count_q,
  output logic              ovf_pulse
);
  tmr_cfg_t cfg;
  logic cyc_tick, pin_evt, src_evt, gated_evt, gate_open, cnt_inc;

  assign cfg = '{src: cnt_src_e'(cfg_src_pin), edge_fall: cfg_edge_fall,
                 psc_on: cfg_psc_on, rate: 3'(cfg_rate)};

  evtt_phase #(.CLK_PER_CYC(CLK_PER_CYC)) u_phase (
    .clk(clk), .rst(rst), .cyc_tick(cyc_tick));

  evtt_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .pin(cnt_pin), .fall_sel(cfg.edge_fall),
    .pin_evt(pin_evt));

  assign src_evt   = (cfg.src == SRC_PIN) ? pin_evt : cyc_tick;
  assign gated_evt = src_evt & gate_open & ~wr_en;

  evtt_prescale #(.PSC_W(PSC_W), .RATE_W(RATE_W)) u_psc (
    .clk(clk), .rst(rst), .clr(wr_en), .on(cfg.psc_on),
    .rate(RATE_W'(cfg.rate)), .evt(gated_evt), .inc(cnt_inc));

  evtt_core #(.CNT_W(CNT_W), .INH_CYC(INH_CYC)) u_core (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .cyc_tick(cyc_tick), .inc(cnt_inc), .gate_open(gate_open),
    .count_q(count_q), .ovf_q(ovf_pulse));
endmodule

// File: rtl/evt_timer8_chk.sv
module evt_timer8_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [CNT_W-1:0] wr_data,
  input logic [CNT_W-1:0] count_q,
  input logic             ovf_pulse
);
  // R8
  ovf_single_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |=> !ovf_pulse);

  // R8
  ovf_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |-> (count_q == '0));

  // R2
  load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (count_q == $past(wr_data)));

  // R7
  hold_after_load_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && !wr_en) |=> (count_q == $past(count_q)));

  // R9
  step_only_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_en) && (count_q != $past(count_q)))
      |-> (count_q == CNT_W'($past(count_q) + CNT_W'(1))));
endmodule

bind evt_timer8 evt_timer8_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
  .count_q(count_q), .ovf_pulse(ovf_pulse));

// File: tb/sim_evt_timer8.sv
`timescale 1ns/1ps
module sim_evt_timer8;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_pin = 1'b0, cfg_src_pin = 1'b0, cfg_edge_fall = 1'b0;
  logic       cfg_psc_on = 1'b0, wr_en = 1'b0;
  logic [2:0] cfg_rate = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] count_q;
  logic       ovf_pulse;

  int tests = 0, fails = 0, edges = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // index of the next clock edge since reset release
  always @(posedge clk) if (!rst) edges <= edges + 1;

  evt_timer8 u0 (.clk(clk), .rst(rst), .cnt_pin(cnt_pin),
    .cfg_src_pin(cfg_src_pin), .cfg_edge_fall(cfg_edge_fall),
    .cfg_psc_on(cfg_psc_on), .cfg_rate(cfg_rate), .wr_en(wr_en),
    .wr_data(wr_data), .count_q(count_q), .ovf_pulse(ovf_pulse));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (edge %0d)", req, act, exp, edges);
    end
  endtask

  task automatic wait_until(input int target);
    while (edges < target) @(negedge clk);
  endtask

  // write on an instruction-cycle-aligned edge E; returns E
  task automatic do_write(input logic [7:0] v, output int e);
    @(negedge clk);
    while (edges % 4 != 0) @(negedge clk);
    e = edges;
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R2 load", count_q, v);
  endtask

  task automatic t_reset();
    chk("R1 count in reset", count_q, 0);
    chk("R1 ovf in reset", ovf_pulse, 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 count after reset", count_q, 0);
    chk("R1 ovf after reset", ovf_pulse, 0);
  endtask

  task automatic t_timer_base();
    int e;
    cfg_src_pin = 1'b0; cfg_psc_on = 1'b0;
    do_write(8'h40, e);
    wait_until(e + 8);  chk("R7 two cycles swallowed", count_q, 8'h40);
    wait_until(e + 11); chk("R3 before first step", count_q, 8'h40);
    wait_until(e + 12); chk("R3 first step", count_q, 8'h41);
    wait_until(e + 15); chk("R3 hold within cycle", count_q, 8'h41);
    wait_until(e + 16); chk("R3 second step", count_q, 8'h42);
    wait_until(e + 20); chk("R3 third step", count_q, 8'h43);
  endtask

  task automatic t_prescale(input int n);
    int e, r, first;
    cfg_src_pin = 1'b0; cfg_psc_on = 1'b1; cfg_rate = 3'(n);
    repeat (22) @(negedge clk);
    do_write(8'h10, e);
    r = 1 << (n + 1);
    first = e + 11 + 4 * (r - 1);
    wait_until(first);         chk($sformatf("R6 n=%0d before step", n), count_q, 8'h10);
    wait_until(first + 1);     chk($sformatf("R6 n=%0d first step (R7 clear)", n), count_q, 8'h11);
    wait_until(first + 4 * r); chk($sformatf("R6 n=%0d hold", n), count_q, 8'h11);
    wait_until(first + 4 * r + 1); chk($sformatf("R6 n=%0d second step", n), count_q, 8'h12);
    cfg_psc_on = 1'b0;
  endtask

  task automatic t_overflow();
    int e;
    cfg_src_pin = 1'b0; cfg_psc_on = 1'b0;
    do_write(8'hFE, e);
    wait_until(e + 12); chk("R8 at FF", count_q, 8'hFF);
    chk("R8 no pulse before wrap", ovf_pulse, 0);
    wait_until(e + 15); chk("R8 no pulse yet", ovf_pulse, 0);
    wait_until(e + 16); chk("R8 pulse on wrap", ovf_pulse, 1);
    chk("R8 count zero at pulse", count_q, 0);
    wait_until(e + 17); chk("R8 pulse one clock", ovf_pulse, 0);
  endtask

  task automatic t_pin_rise();
    int e, a;
    cfg_src_pin = 1'b1; cfg_edge_fall = 1'b0; cnt_pin = 1'b0;
    do_write(8'h20, e);
    wait_until(e + 14); chk("R4 cycle strobe ignored", count_q, 8'h20);
    for (int k = 1; k <= 3; k++) begin
      a = edges; cnt_pin = 1'b1;
      wait_until(a + 2); chk("R4 sync latency", count_q, 8'h20 + k - 1);
      wait_until(a + 3); chk("R4 rising step", count_q, 8'h20 + k);
      cnt_pin = 1'b0;
      wait_until(a + 7); chk("R4 falling ignored", count_q, 8'h20 + k);
    end
  endtask

  task automatic t_pin_fall();
    int e, a;
    cfg_src_pin = 1'b1; cfg_edge_fall = 1'b1; cnt_pin = 1'b0;
    do_write(8'h50, e);
    wait_until(e + 14);
    a = edges; cnt_pin = 1'b1;
    wait_until(a + 4); chk("R5 rising ignored", count_q, 8'h50);
    a = edges; cnt_pin = 1'b0;
    wait_until(a + 2); chk("R5 sync latency", count_q, 8'h50);
    wait_until(a + 3); chk("R5 falling step", count_q, 8'h51);
    cfg_src_pin = 1'b0; cfg_edge_fall = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_timer_base();
    t_prescale(0);
    t_prescale(2);
    t_prescale(7);
    t_overflow();
    t_pin_rise();
    t_pin_fall();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule